// File: doc/BRIEF.md
# Host Bridge PCI Configuration Header (First Four Dwords)

This block holds the first sixteen bytes of a Type 0 configuration header for a host bridge at bus 0, device 0, function 0. Configuration accesses reach it already decoded. Each access carries three things: a dword index, four byte enables and a 32-bit data word.

A read returns a dword immediately, in the same cycle the index is presented. That dword is built from four kinds of field:
- constant identification fields,
- the single writable command bit,
- the latency timer,
- four sticky error flags in the status word.

A write takes effect at the next clock edge, and only in the bytes whose enable is set.

Error event inputs from the bus logic set the sticky status flags. Software clears a flag by writing a one to its bit position. A write of zero to a flag has no effect. The stored latency timer value is also driven on a separate output for the bus arbiter.

Top module: `pci_cfg_hdr`

## Requirements
- R1: Dword index 0 reads {device ID, vendor ID}, with the vendor ID in bits 15:0. Both values are fixed by parameters, and writes to this dword have no effect.
- R2: The command word (dword 1, bits 15:0) reads 0006h after reset. Every command bit other than bit 6 keeps its reset value, whatever is written.
- R3: Command bit 6 (parity response enable) is stored from write-data bit 6 when byte enable 0 is set on a write to dword 1.
- R4: The status word (dword 1, bits 31:16) reads 0210h after reset. All its bits except 15, 13, 12 and 8 keep their reset value at all times.
- R5: Status bits 15, 13, 12 and 8 are sticky. Writing a one to a flag's position (write-data bits 31, 29, 28, 24 with byte enable 3) clears that flag. Writing a zero leaves it unchanged.
- R6: Status bit 15 sets one cycle after an address-phase or data-phase parity event, whatever the value of command bit 6.
- R7: Status bit 8 sets on a data-phase parity event only when command bit 6 is 1 and the bridge was the initiator. Command bit 6 is taken as it stood before that edge.
- R8: Status bit 13 sets on a signaled master abort event. Status bit 12 sets on a received target abort event.
- R9: When a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R10: Dword index 2 reads {06h, 00h, 00h, revision}, with the revision in bits 7:0 and fixed by a parameter.
- R11: The latency timer sits in dword 3, bits 15:8. Its bits 7:3 are written from write-data bits 15:11 when byte enable 1 is set, and they reset to 0. Bits 2:0 always read 0. The `lat_timer` output always equals this byte.
- R12: A byte whose enable is clear is not changed by a write.
- R13: The following read as zero and are not changed by writes: bytes 0, 2 and 3 of dword 3, and every dword index of 4 or above. A write to an index of 4 or above does not alter dwords 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the access in this cycle |
| cfg_idx | input | IDX_W | Dword index of the access |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_idx`, combinational |
| ev_addr_perr | input | 1 | Address-phase parity error seen |
| ev_data_perr | input | 1 | Data-phase parity error seen |
| ev_initiator | input | 1 | The bridge initiated the transaction of the data parity error |
| ev_mabort | input | 1 | The bridge signaled a master abort |
| ev_tabort_rcvd | input | 1 | The bridge received a target abort |
| lat_timer | output | 8 | Stored latency timer byte, with bits 2:0 always zero |

## Verification
Every piece of state in this block is visible through the read port, and reads are combinational. A flag, enable bit or timer value that is wrong after an edge therefore shows up on `cfg_rdata` the next time its dword is addressed. For the latency timer it shows up on `lat_timer` in the cycle right after the faulty edge.

The most telling errors are in the ordering of clear and set:
- A lost set-over-clear priority shows as a cleared flag one cycle after a colliding event.
- A parity gate that reads the updated enable instead of the old one shows as a wrong bit 8 in the cycle after the enable is written.

The reference model compares the addressed dword and the timer output on every clock. Because of that, such a fault is reported at the first cycle it becomes visible, not at the end of a sequence.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [15:0] CMD_FIXED     = 16'h0006;
    localparam int          CMD_PERR_BIT  = 6;
    localparam logic [15:0] STAT_FIXED    = 16'h0210;
    localparam logic [7:0]  CLASS_BRIDGE  = 8'h06;
    localparam logic [7:0]  SUBCLASS_HOST = 8'h00;
    localparam logic [7:0]  PROGIF_NONE   = 8'h00;

    typedef enum logic [1:0] {
        DW_ID      = 2'd0,
        DW_CMDSTAT = 2'd1,
        DW_CLASS   = 2'd2,
        DW_MISC    = 2'd3
    } hdr_dw_e;

    typedef struct packed {
        logic det_perr;    // status bit 15
        logic sig_mabort;  // status bit 13
        logic rcv_tabort;  // status bit 12
        logic data_perr;   // status bit 8
    } stat_flags_t;

    function automatic logic [15:0] pack_status(input stat_flags_t f);
        logic [15:0] s;
        s     = STAT_FIXED;
        s[15] = f.det_perr;
        s[13] = f.sig_mabort;
        s[12] = f.rcv_tabort;
        s[8]  = f.data_perr;
        return s;
    endfunction

    function automatic logic [15:0] pack_command(input logic perr_en);
        logic [15:0] c;
        c               = CMD_FIXED;
        c[CMD_PERR_BIT] = perr_en;
        return c;
    endfunction

    // Status byte (bits 15:8) as it lands in data bits 31:24 -> clear mask
    function automatic stat_flags_t w1c_mask(input logic [7:0] hi_byte);
        stat_flags_t m;
        m.det_perr   = hi_byte[7];
        m.sig_mabort = hi_byte[5];
        m.rcv_tabort = hi_byte[4];
        m.data_perr  = hi_byte[0];
        return m;
    endfunction

endpackage

// File: rtl/pci_cfg_cmd.sv
module pci_cfg_cmd (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    output logic perr_en
);
    always_ff @(posedge clk) begin
        if (rst)        perr_en <= 1'b0;
        else if (wr_en) perr_en <= wr_bit;
    end
endmodule

// File: rtl/pci_cfg_status.sv
module pci_cfg_status
    import pci_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stat_flags_t clr,
    input  stat_flags_t set,
    output stat_flags_t flags
);
    // set dominates a coincident clear
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | set;
    end
endmodule

// File: rtl/pci_cfg_lat.sv
module pci_cfg_lat #(
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LAT_W-1:0] wr_val,
    output logic [7:0]       lat_byte
);
    localparam int LSB_W = 8 - LAT_W;

    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst)        lat_q <= '0;
        else if (wr_en) lat_q <= wr_val;
    end

    assign lat_byte = {lat_q, {LSB_W{1'b0}}};
endmodule

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr
    import pci_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1D17,
    parameter logic [15:0] DEVICE_ID = 16'h0301,
    parameter logic [7:0]  REV_ID    = 8'h01,
    parameter int          IDX_W     = 6,
    parameter int          LAT_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              ev_addr_perr,
    input  logic              ev_data_perr,
    input  logic              ev_initiator,
    input  logic              ev_mabort,
    input  logic              ev_tabort_rcvd,
    output logic [7:0]        lat_timer
);
    localparam int LAT_HI = 15;
    localparam int LAT_LO = LAT_HI - LAT_W + 1;

    logic        hit;
    hdr_dw_e     dw_sel;
    logic [BE_W-1:0] lane_wr;
    logic        perr_en;
    stat_flags_t stat_q;
    stat_flags_t stat_clr;
    stat_flags_t stat_set;

    assign hit    = (cfg_idx[IDX_W-1:2] == '0);
    assign dw_sel = hdr_dw_e'(cfg_idx[1:0]);

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign lane_wr[b] = cfg_we & hit & cfg_be[b];
    end

    pci_cfg_cmd u_cmd (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lane_wr[0] && dw_sel == DW_CMDSTAT),
        .wr_bit  (cfg_wdata[CMD_PERR_BIT]),
        .perr_en (perr_en)
    );

    always_comb begin
        stat_clr = '0;
        if (lane_wr[3] && dw_sel == DW_CMDSTAT)
            stat_clr = w1c_mask(cfg_wdata[31:24]);
        stat_set.det_perr   = ev_addr_perr | ev_data_perr;
        stat_set.sig_mabort = ev_mabort;
        stat_set.rcv_tabort = ev_tabort_rcvd;
        stat_set.data_perr  = ev_data_perr & ev_initiator & perr_en;
    end

    pci_cfg_status u_status (
        .clk   (clk),
        .rst   (rst),
        .clr   (stat_clr),
        .set   (stat_set),
        .flags (stat_q)
    );

    pci_cfg_lat #(.LAT_W(LAT_W)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (lane_wr[1] && dw_sel == DW_MISC),
        .wr_val   (cfg_wdata[LAT_HI:LAT_LO]),
        .lat_byte (lat_timer)
    );

    always_comb begin
        cfg_rdata = '0;
        if (hit) begin
            unique case (dw_sel)
                DW_ID:      cfg_rdata = {DEVICE_ID, VENDOR_ID};
                DW_CMDSTAT: cfg_rdata = {pack_status(stat_q), pack_command(perr_en)};
                DW_CLASS:   cfg_rdata = {CLASS_BRIDGE, SUBCLASS_HOST, PROGIF_NONE, REV_ID};
                DW_MISC:    cfg_rdata = {16'h0000, lat_timer, 8'h00};
                default:    cfg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pci_cfg_hdr_chk.sv
module pci_cfg_hdr_chk
    import pci_cfg_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic [BE_W-1:0]   cfg_be,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              ev_addr_perr,
    input logic              ev_data_perr,
    input logic              ev_initiator,
    input logic              ev_mabort,
    input logic              ev_tabort_rcvd,
    input logic [7:0]        lat_timer,
    input logic              perr_en,
    input stat_flags_t       stat_q
);
    // R2
    cmd_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_idx == IDX_W'(1)) |-> ((cfg_rdata[15:0] & 16'hFFBF) == 16'h0006));

    // R4
    stat_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_idx == IDX_W'(1)) |-> ((cfg_rdata[31:16] & 16'h4EFF) == 16'h0210));

    // R5
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_idx == IDX_W'(1) && cfg_be[3] && cfg_wdata[29] && !ev_mabort)
        |=> !stat_q.sig_mabort);

    // R6
    det_perr_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_addr_perr || ev_data_perr) |=> stat_q.det_perr);

    // R7
    data_perr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.data_perr) |-> $past(ev_data_perr && ev_initiator && perr_en));

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ev_tabort_rcvd |=> stat_q.rcv_tabort);

    // R11
    lat_granule_chk: assert property (@(posedge clk) disable iff (rst)
        lat_timer[2:0] == 3'b000);

    // R13
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_idx[IDX_W-1:2] != '0) |-> (cfg_rdata == '0));
endmodule

bind pci_cfg_hdr pci_cfg_hdr_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/pci_cfg_hdr_bench.sv
module pci_cfg_hdr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 6;
    localparam logic [15:0] VEN = 16'h1AB4;
    localparam logic [15:0] DEV = 16'h0C21;
    localparam logic [7:0]  REV = 8'h03;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ev_addr_perr = 1'b0, ev_data_perr = 1'b0, ev_initiator = 1'b0;
    logic        ev_mabort = 1'b0, ev_tabort_rcvd = 1'b0;
    logic [7:0]  lat_timer;

    int checks = 0;
    int errors = 0;

    // reference state
    bit m_perr, m_s15, m_s13, m_s12, m_s8;
    int m_lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_cfg_hdr #(.VENDOR_ID(VEN), .DEVICE_ID(DEV), .REV_ID(REV), .IDX_W(IDX_W)) u_pci_cfg_hdr (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ev_addr_perr(ev_addr_perr),
        .ev_data_perr(ev_data_perr), .ev_initiator(ev_initiator), .ev_mabort(ev_mabort),
        .ev_tabort_rcvd(ev_tabort_rcvd), .lat_timer(lat_timer)
    );

    function automatic logic [31:0] model_read(int idx);
        logic [15:0] cmd, st;
        cmd = 16'h0006 | (m_perr ? 16'h0040 : 16'h0);
        st  = 16'h0210 | {m_s15, 1'b0, m_s13, m_s12, 3'b000, m_s8, 8'h00};
        case (idx)
            0: return {DEV, VEN};
            1: return {st, cmd};
            2: return {8'h06, 8'h00, 8'h00, REV};
            3: return {16'h0, 8'(m_lat * 8), 8'h00};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // ev = {tabort, mabort, initiator, data_perr, addr_perr}
    task automatic step(string req, bit we, int idx, logic [3:0] be, logic [31:0] wd, logic [4:0] ev);
        bit n_perr, c15, c13, c12, c8;
        int n_lat;
        @(negedge clk);
        cfg_we = we; cfg_idx = IDX_W'(idx); cfg_be = be; cfg_wdata = wd;
        {ev_tabort_rcvd, ev_mabort, ev_initiator, ev_data_perr, ev_addr_perr} = ev;
        #1;
        check(req, cfg_rdata, model_read(idx));
        check(req, {24'h0, lat_timer}, 32'(m_lat * 8));
        n_perr = m_perr; n_lat = m_lat; {c15, c13, c12, c8} = '0;
        if (we && idx == 1) begin
            if (be[0]) n_perr = wd[6];
            if (be[3]) {c15, c13, c12, c8} = {wd[31], wd[29], wd[28], wd[24]};
        end
        if (we && idx == 3 && be[1]) n_lat = int'(wd[15:11]);
        m_s15 = (m_s15 & !c15) | ev[0] | ev[1];
        m_s13 = (m_s13 & !c13) | ev[3];
        m_s12 = (m_s12 & !c12) | ev[4];
        m_s8  = (m_s8  & !c8)  | (ev[1] & ev[2] & m_perr);
        m_perr = n_perr; m_lat = n_lat;
    endtask

    task automatic rd(string req, int idx);
        step(req, 1'b0, idx, 4'h0, 32'h0, 5'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        {m_perr, m_s15, m_s13, m_s12, m_s8} = '0; m_lat = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state
        rd("R1", 0); rd("R2 R4", 1); rd("R10", 2); rd("R11", 3); rd("R13", 5);
        // R1 writes to id dword ignored
        step("R1", 1, 0, 4'hF, 32'h0000_0000, 5'b0); rd("R1", 0);
        // R2 R3 command writes
        step("R3", 1, 1, 4'h1, 32'h0000_FFFF, 5'b0); rd("R2 R3", 1);
        step("R12", 1, 1, 4'h0, 32'h0000_0000, 5'b0); rd("R12", 1);
        step("R3", 1, 1, 4'h1, 32'h0000_0000, 5'b0); rd("R3", 1);
        step("R3", 1, 1, 4'h1, 32'h0000_0040, 5'b0); rd("R3", 1);
        // R6 address parity, R7 data parity gating
        step("R6", 0, 1, 4'h0, 32'h0, 5'b00001); rd("R6", 1);
        step("R7", 0, 1, 4'h0, 32'h0, 5'b00010); rd("R7", 1);
        step("R5", 1, 1, 4'h8, 32'h8000_0000, 5'b0); rd("R5", 1);
        step("R7", 0, 1, 4'h0, 32'h0, 5'b00110); rd("R7", 1);
        step("R5", 1, 1, 4'h8, 32'h8100_0000, 5'b0); rd("R5", 1);
        // R7 enable written in the same cycle as the event: old value counts
        step("R7", 1, 1, 4'h1, 32'h0000_0000, 5'b00110); rd("R7", 1);
        step("R7", 0, 1, 4'h0, 32'h0, 5'b00110); rd("R6 R7", 1);
        // R8 aborts
        step("R8", 0, 1, 4'h0, 32'h0, 5'b01000); rd("R8", 1);
        step("R8", 0, 1, 4'h0, 32'h0, 5'b10000); rd("R8", 1);
        // R5 zero write keeps, one clears selectively
        step("R5", 1, 1, 4'hF, 32'h0000_0000, 5'b0); rd("R5", 1);
        step("R5", 1, 1, 4'h8, 32'h2000_0000, 5'b0); rd("R5", 1);
        step("R8", 0, 1, 4'h0, 32'h0, 5'b01000); rd("R8", 1);
        // R12 clear without byte enable 3
        step("R12", 1, 1, 4'h7, 32'hFFFF_FFFF, 5'b0); rd("R12", 1);
        // R9 set beats clear
        step("R9", 1, 1, 4'h8, 32'h3000_0000, 5'b11000); rd("R9", 1);
        step("R9", 1, 1, 4'h8, 32'hB100_0000, 5'b00001); rd("R9", 1);
        step("R5", 1, 1, 4'h8, 32'hFF00_0000, 5'b0); rd("R5", 1);
        // R11 latency timer
        step("R11", 1, 3, 4'h2, 32'h0000_FF00, 5'b0); rd("R11", 3);
        step("R12", 1, 3, 4'hD, 32'h0000_0000, 5'b0); rd("R12 R13", 3);
        step("R11", 1, 3, 4'hF, 32'hFFFF_5AFF, 5'b0); rd("R11 R13", 3);
        // R13 unimplemented indices
        step("R13", 1, 5, 4'hF, 32'hFFFF_FFFF, 5'b0); rd("R13", 5);
        step("R13", 1, 7, 4'hF, 32'h0000_FF00, 5'b0); rd("R13", 3);
        step("R13", 1, 37, 4'hF, 32'h0000_0040, 5'b0); rd("R13", 1);
        step("R13", 1, 6, 4'hF, 32'h0000_0000, 5'b0); rd("R10", 2);
        rd("R1", 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule